// File: doc/BRIEF.md
# Master Address-Modifier and Transfer-Width Selector

This block runs beside the outbound master of a VMEbus interface. When the local processor starts a bus access, the selector picks the 6-bit address-modifier (AM) code that goes with it. It also reports which data widths (D8, D16, D32) the transfer may use. Both results are latched on the clock edge that starts the access and stay unchanged until the access finishes.

The choice depends on the 32-bit local address, the three processor function-code lines and a small configuration latch. The latch holds four settings: a narrow-data force, a standard-address force, a short-address force, and an optional programmed AM code that replaces the automatic choice.

Fixed address windows take priority over the configuration:
- The top 64 KiB of the address space always uses short addressing.
- The low 16 MiB always uses standard addressing.
- The top 256 MiB never gets 32-bit data.

The function-code lines choose the supervisory or non-privileged variant, and the program or data variant, within the chosen addressing class. Bus timing, data steering and arbitration are handled by other blocks.

Top module: `vme_am_select`

## Requirements
- R1: While reset is low, and on the first cycle after it, `amValid`, `amCode` and all three width flags read 0, and the configuration latch is cleared (no forces, programmed AM disabled).
- R2: A high `cycleStart` at a clock edge while idle captures the access; from the next cycle on, `amValid` is 1 and the outputs stay constant. A high `cycleEnd` at a clock edge while active ends the access; from the next cycle on, `amValid` is 0 and all width flags are 0, while `amCode` keeps its last value.
- R3: `cycleStart` while an access is already active is ignored: the outputs keep the captured values.
- R4: If the short-address force is set, or the address is at or above 0xFFFF0000, the code is a short code: 0x2D for a supervisor access and 0x29 for a user access. This takes priority over R5.
- R5: Otherwise, if the standard-address force is set, or the address is below 0x01000000, the code is a standard code: supervisor program 0x3E, supervisor data 0x3D, user program 0x3A, user data 0x39.
- R6: Otherwise the code is an extended code: supervisor program 0x0E, supervisor data 0x0D, user program 0x0A, user data 0x09.
- R7: Function-code bit 2 = 1 marks a supervisor access. Function-code bits [1:0] = 2'b10 mark a program access. Every other value of bits [1:0] is a data access.
- R8: When the programmed-AM enable is set, `amCode` equals the programmed 6-bit value, whatever the address and function codes are. The width flags are unaffected.
- R9: During an access, D8 and D16 are always allowed. D32 is allowed only when the narrow-data force is clear and the address is below 0xF0000000.
- R10: A `cfgLoad` pulse writes the configuration inputs at that clock edge. An access captured at that same edge still uses the previous configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous system reset |
| cfgLoad | input | 1 | Write strobe for the configuration latch |
| cfgForceD16 | input | 1 | Narrow-data force value |
| cfgForceA24 | input | 1 | Standard-address force value |
| cfgForceA16 | input | 1 | Short-address force value |
| cfgProgEn | input | 1 | Programmed-AM enable value |
| cfgProgAm | input | 6 | Programmed AM code value |
| cycleStart | input | 1 | Access start strobe |
| cycleEnd | input | 1 | Access end strobe |
| addr | input | 32 | Local address of the access |
| fc | input | 3 | Processor function codes |
| amValid | output | 1 | An access is active and the outputs are valid |
| amCode | output | 6 | Selected address-modifier code |
| allowD8 | output | 1 | Byte transfers allowed |
| allowD16 | output | 1 | 16-bit transfers allowed |
| allowD32 | output | 1 | 32-bit transfers allowed |

## Verification
The assertions assume that the address, function codes and configuration matter only at the capture edge, and that `cycleEnd` matters only while an access is active. For that reason they state no stability rules for these inputs between edges.

The stimulus deliberately breaks the usual pairing rules:
- it raises `cycleStart` during active accesses;
- it raises `cycleStart` and `cycleEnd` together;
- it pulses `cfgLoad` on the same edge as a capture.

All inputs change on the falling edge, so the behavioural model and the design always see settled values. Addresses are drawn from each window and from the exact window boundaries.

// File: rtl/vam_pkg.sv
package vam_pkg;

  localparam int AM_W = 6;
  localparam int FC_W = 3;

  typedef struct packed {
    logic            forceD16;
    logic            forceA24;
    logic            forceA16;
    logic            progAmEn;
    logic [AM_W-1:0] progAm;
  } vamCfg_t;

  typedef struct packed {
    logic capture;
    logic retire;
  } vamStrobe_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } vamState_t;

  typedef enum logic [1:0] {
    CLS_EXT   = 2'd0,
    CLS_STD   = 2'd1,
    CLS_SHORT = 2'd2
  } amClass_t;

endpackage

// File: rtl/vam_ctrl.sv
module vam_ctrl
  import vam_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            cfgLoad,
  input  logic            cfgForceD16,
  input  logic            cfgForceA24,
  input  logic            cfgForceA16,
  input  logic            cfgProgEn,
  input  logic [AM_W-1:0] cfgProgAm,
  input  logic            cycleStart,
  input  logic            cycleEnd,
  output vamCfg_t         cfgQ,
  output vamStrobe_t      strb,
  output logic            busy
);

  vamState_t stateQ, stateD;

  // Configuration latch, cleared by system reset (R1, R10)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ <= '0;
    end else if (cfgLoad) begin
      cfgQ.forceD16 <= cfgForceD16;
      cfgQ.forceA24 <= cfgForceA24;
      cfgQ.forceA16 <= cfgForceA16;
      cfgQ.progAmEn <= cfgProgEn;
      cfgQ.progAm   <= cfgProgAm;
    end
  end

  always_comb begin
    strb.capture = (stateQ == ST_IDLE) && cycleStart;
    strb.retire  = (stateQ == ST_BUSY) && cycleEnd;
    stateD       = stateQ;
    if (strb.capture) stateD = ST_BUSY;
    else if (strb.retire) stateD = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign busy = (stateQ == ST_BUSY);

  // R2: a start seen while idle makes the access active on the next cycle
  a_r2_start_activates: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && cycleStart) |=> busy);

  // R2: an end seen while active makes the block idle on the next cycle
  a_r2_end_retires: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cycleEnd) |=> !busy);

  // R3: a start while active does not end or restart the access
  a_r3_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cycleStart && !cycleEnd) |=> busy);

endmodule

// File: rtl/vam_datapath.sv
module vam_datapath
  import vam_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] STD_LIMIT  = 32'h0100_0000,
  parameter logic [ADDR_W-1:0] WIDE_LIMIT = 32'hF000_0000,
  parameter logic [ADDR_W-1:0] SHORT_BASE = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  vamStrobe_t        strb,
  input  vamCfg_t           cfg,
  input  logic [ADDR_W-1:0] addr,
  input  logic [FC_W-1:0]   fc,
  output logic [AM_W-1:0]   amCode,
  output logic              allowD8,
  output logic              allowD16,
  output logic              allowD32
);

  localparam logic [AM_W-1:0] AM_SHORT_SUP = 6'h2D;
  localparam logic [AM_W-1:0] AM_SHORT_USR = 6'h29;

  amClass_t        cls;
  logic            inShortWin, inStdWin, isSuper, isProg, nextD32;
  logic [AM_W-1:0] tableAm, nextAm;

  // Window comparators: the short window outranks the standard window (R4, R5, R6)
  always_comb begin
    inShortWin = cfg.forceA16 || (addr >= SHORT_BASE);
    inStdWin   = cfg.forceA24 || (addr < STD_LIMIT);
    if (inShortWin)    cls = CLS_SHORT;
    else if (inStdWin) cls = CLS_STD;
    else               cls = CLS_EXT;
  end

  // Function-code decode (R7)
  assign isSuper = fc[2];
  assign isProg  = fc[1] & ~fc[0];

  always_comb begin
    unique case (cls)
      CLS_SHORT: tableAm = isSuper ? AM_SHORT_SUP : AM_SHORT_USR;
      CLS_STD: begin
        case ({isSuper, isProg})
          2'b11:   tableAm = 6'h3E;
          2'b10:   tableAm = 6'h3D;
          2'b01:   tableAm = 6'h3A;
          default: tableAm = 6'h39;
        endcase
      end
      default: begin
        case ({isSuper, isProg})
          2'b11:   tableAm = 6'h0E;
          2'b10:   tableAm = 6'h0D;
          2'b01:   tableAm = 6'h0A;
          default: tableAm = 6'h09;
        endcase
      end
    endcase
  end

  assign nextAm  = cfg.progAmEn ? cfg.progAm : tableAm;               // R8
  assign nextD32 = !cfg.forceD16 && (addr < WIDE_LIMIT);              // R9

  // Capture registers, held until retire (R2, R3)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      amCode   <= '0;
      allowD8  <= 1'b0;
      allowD16 <= 1'b0;
      allowD32 <= 1'b0;
    end else if (strb.capture) begin
      amCode   <= nextAm;
      allowD8  <= 1'b1;
      allowD16 <= 1'b1;
      allowD32 <= nextD32;
    end else if (strb.retire) begin
      allowD8  <= 1'b0;
      allowD16 <= 1'b0;
      allowD32 <= 1'b0;
    end
  end

  // R9: the narrow-data force removes D32
  a_r9_force_narrow: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && cfg.forceD16) |=> !allowD32);

  // R9: the top window never gets D32
  a_r9_high_window_narrow: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && (addr >= WIDE_LIMIT)) |=> !allowD32);

  // R4: the top 64 KiB gives a short code unless the programmed AM is enabled
  a_r4_short_window: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && !cfg.progAmEn && (addr >= SHORT_BASE))
      |=> (amCode == AM_SHORT_SUP || amCode == AM_SHORT_USR));

  // R8: the programmed code is presented as written
  a_r8_prog_override: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && cfg.progAmEn) |=> (amCode == $past(cfg.progAm)));

endmodule

// File: rtl/vme_am_select.sv
module vme_am_select
  import vam_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] STD_LIMIT  = 32'h0100_0000,
  parameter logic [ADDR_W-1:0] WIDE_LIMIT = 32'hF000_0000,
  parameter logic [ADDR_W-1:0] SHORT_BASE = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgLoad,
  input  logic              cfgForceD16,
  input  logic              cfgForceA24,
  input  logic              cfgForceA16,
  input  logic              cfgProgEn,
  input  logic [5:0]        cfgProgAm,
  input  logic              cycleStart,
  input  logic              cycleEnd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        fc,
  output logic              amValid,
  output logic [5:0]        amCode,
  output logic              allowD8,
  output logic              allowD16,
  output logic              allowD32
);

  vamCfg_t    cfgQ;
  vamStrobe_t strb;

  vam_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cfgLoad     (cfgLoad),
    .cfgForceD16 (cfgForceD16),
    .cfgForceA24 (cfgForceA24),
    .cfgForceA16 (cfgForceA16),
    .cfgProgEn   (cfgProgEn),
    .cfgProgAm   (cfgProgAm),
    .cycleStart  (cycleStart),
    .cycleEnd    (cycleEnd),
    .cfgQ        (cfgQ),
    .strb        (strb),
    .busy        (amValid)
  );

  vam_datapath #(
    .ADDR_W     (ADDR_W),
    .STD_LIMIT  (STD_LIMIT),
    .WIDE_LIMIT (WIDE_LIMIT),
    .SHORT_BASE (SHORT_BASE)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .cfg      (cfgQ),
    .addr     (addr),
    .fc       (fc),
    .amCode   (amCode),
    .allowD8  (allowD8),
    .allowD16 (allowD16),
    .allowD32 (allowD32)
  );

  // R2, R3: the outputs hold still while an access continues
  a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    (amValid && !cycleEnd) |=> (amValid && $stable(amCode) && $stable(allowD32)));

  // R9: the narrow widths are always granted during an access
  a_r9_narrow_granted: assert property (@(posedge clk) disable iff (!rstN)
    amValid |-> (allowD8 && allowD16));

  // R2: no width is granted outside an access
  a_r2_flags_idle: assert property (@(posedge clk) disable iff (!rstN)
    !amValid |-> !(allowD8 || allowD16 || allowD32));

endmodule

// File: tb/vme_am_select_bench.sv
`timescale 1ns/1ps
module vme_am_select_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgLoad = 1'b0, cfgForceD16 = 1'b0, cfgForceA24 = 1'b0, cfgForceA16 = 1'b0;
  logic        cfgProgEn = 1'b0;
  logic [5:0]  cfgProgAm = '0;
  logic        cycleStart = 1'b0, cycleEnd = 1'b0;
  logic [31:0] addr = '0;
  logic [2:0]  fc = '0;
  logic        amValid, allowD8, allowD16, allowD32;
  logic [5:0]  amCode;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  vme_am_select u_vme_am_select (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgForceD16(cfgForceD16),
    .cfgForceA24(cfgForceA24), .cfgForceA16(cfgForceA16), .cfgProgEn(cfgProgEn),
    .cfgProgAm(cfgProgAm), .cycleStart(cycleStart), .cycleEnd(cycleEnd),
    .addr(addr), .fc(fc), .amValid(amValid), .amCode(amCode),
    .allowD8(allowD8), .allowD16(allowD16), .allowD32(allowD32));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural reference model
  bit        mBusy, mD8, mD16, mD32;
  bit        mF16, mF24, mFA16, mPe;
  bit [5:0]  mPam, mAm;

  function automatic bit [5:0] refAm(bit [31:0] a, bit [2:0] f, bit fa16, bit fa24,
                                     bit pe, bit [5:0] pam);
    bit priv, prog;
    bit [5:0] base;
    if (pe) return pam;
    priv = f[2];
    prog = (f == 3'd2) || (f == 3'd6);
    if (fa16 || a >= 32'hFFFF_0000) return priv ? 6'h2D : 6'h29;
    base = (fa24 || a < 32'h0100_0000) ? 6'h38 : 6'h08;
    return base + (priv ? 6'd4 : 6'd0) + (prog ? 6'd2 : 6'd1);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mD8 = 0; mD16 = 0; mD32 = 0; mAm = 0;
      mF16 = 0; mF24 = 0; mFA16 = 0; mPe = 0; mPam = 0;
    end else begin
      if (mBusy) begin
        if (cycleEnd) begin mBusy = 0; mD8 = 0; mD16 = 0; mD32 = 0; end
      end else if (cycleStart) begin
        mBusy = 1; mD8 = 1; mD16 = 1;
        mAm  = refAm(addr, fc, mFA16, mF24, mPe, mPam);
        mD32 = !mF16 && (addr < 32'hF000_0000);
      end
      if (cfgLoad) begin
        mF16 = cfgForceD16; mF24 = cfgForceA24; mFA16 = cfgForceA16;
        mPe = cfgProgEn; mPam = cfgProgAm;
      end
    end
  end

  // Per-cycle comparison against the model (R2, R3, R9 and the rest)
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk("R2 model amValid", amValid, mBusy);
      chk("R3 model amCode", amCode, mAm);
      chk("R9 model widths", {allowD8, allowD16, allowD32}, {mD8, mD16, mD32});
    end
  end

  task automatic loadCfg(bit d16, bit a24, bit a16, bit pe, bit [5:0] pam);
    @(negedge clk);
    cfgLoad = 1; cfgForceD16 = d16; cfgForceA24 = a24; cfgForceA16 = a16;
    cfgProgEn = pe; cfgProgAm = pam;
    @(negedge clk);
    cfgLoad = 0;
  endtask

  task automatic runCycle(string req, bit [31:0] a, bit [2:0] f, bit [5:0] expAm, bit expD32);
    @(negedge clk);
    addr = a; fc = f; cycleStart = 1;
    @(negedge clk);
    cycleStart = 0;
    chk({req, " valid"}, amValid, 1);
    chk({req, " am"}, amCode, expAm);
    chk({req, " d32"}, allowD32, expD32);
    chk("R9 narrow", {allowD8, allowD16}, 2'b11);
    cycleEnd = 1;
    @(negedge clk);
    cycleEnd = 0;
    chk("R2 idle after end", {amValid, allowD8, allowD16, allowD32}, 4'b0000);
    chk("R2 am held after end", amCode, expAm);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset valid", amValid, 0);
    chk("R1 reset am", amCode, 0);
    chk("R1 reset widths", {allowD8, allowD16, allowD32}, 0);
    rstN = 1;
    @(negedge clk);
    chk("R1 after reset", {amValid, amCode, allowD8, allowD16, allowD32}, 0);

    // R1: latch cleared, so a mid address is extended with D32
    runCycle("R1 cleared cfg", 32'h2000_0000, 3'd5, 6'h0D, 1);
    runCycle("R6 sup prog", 32'h2000_0000, 3'd6, 6'h0E, 1);
    runCycle("R6 user data", 32'h7000_0010, 3'd1, 6'h09, 1);
    runCycle("R7 user prog", 32'h7000_0010, 3'd2, 6'h0A, 1);
    runCycle("R7 fc3 data", 32'h7000_0010, 3'd3, 6'h09, 1);
    runCycle("R5 sup data", 32'h00FF_FFFC, 3'd5, 6'h3D, 1);
    runCycle("R5 sup prog", 32'h0000_0000, 3'd6, 6'h3E, 1);
    runCycle("R5 user prog", 32'h0012_3400, 3'd2, 6'h3A, 1);
    runCycle("R5 user data", 32'h0012_3400, 3'd1, 6'h39, 1);
    runCycle("R6 std boundary", 32'h0100_0000, 3'd5, 6'h0D, 1);
    runCycle("R4 short sup", 32'hFFFF_0000, 3'd5, 6'h2D, 0);
    runCycle("R4 short user", 32'hFFFF_1234, 3'd2, 6'h29, 0);
    runCycle("R9 below short", 32'hFFFE_FFFF, 3'd1, 6'h09, 0);
    runCycle("R9 wide edge", 32'hEFFF_FFFF, 3'd5, 6'h0D, 1);
    runCycle("R9 high window", 32'hF000_0000, 3'd5, 6'h0D, 0);

    // R10: load in the same edge as a capture uses the old setting
    @(negedge clk);
    cfgLoad = 1; cfgForceA24 = 1;
    addr = 32'h2000_0000; fc = 3'd5; cycleStart = 1;
    @(negedge clk);
    cfgLoad = 0; cycleStart = 0;
    chk("R10 same edge old cfg", amCode, 6'h0D);
    cycleEnd = 1;
    @(negedge clk);
    cycleEnd = 0;
    runCycle("R10 new cfg A24", 32'h2000_0000, 3'd5, 6'h3D, 1);
    loadCfg(0, 1, 1, 0, 0);
    runCycle("R4 priority over A24", 32'h2000_0000, 3'd5, 6'h2D, 1);
    loadCfg(1, 0, 0, 0, 0);
    runCycle("R9 force narrow", 32'h0000_1000, 3'd1, 6'h39, 0);
    loadCfg(0, 0, 0, 1, 6'h1F);
    runCycle("R8 prog override low", 32'h0000_1000, 3'd6, 6'h1F, 1);
    runCycle("R8 prog override short", 32'hFFFF_8000, 3'd1, 6'h1F, 0);
    loadCfg(0, 0, 0, 0, 0);

    // R3: a second start during an active access leaves outputs alone
    @(negedge clk);
    addr = 32'h0000_2000; fc = 3'd5; cycleStart = 1;
    @(negedge clk);
    addr = 32'hFFFF_0004; fc = 3'd1;
    @(negedge clk);
    cycleStart = 0;
    chk("R3 ignored start am", amCode, 6'h3D);
    chk("R3 ignored start d32", allowD32, 1);
    cycleEnd = 1;
    @(negedge clk);
    cycleEnd = 0;

    // Randomised traffic against the model
    for (int i = 0; i < 600; i++) begin
      int cat;
      @(negedge clk);
      cat = $urandom_range(0, 4);
      case (cat)
        0: addr = $urandom & 32'h00FF_FFFF;
        1: addr = 32'h0100_0000 + ($urandom % 32'hEF00_0000);
        2: addr = 32'hF000_0000 + ($urandom % 32'h0FFF_0000);
        3: addr = 32'hFFFF_0000 | ($urandom & 32'h0000_FFFF);
        default: begin
          int b;
          b = $urandom_range(0, 3);
          addr = (b == 0) ? 32'h00FF_FFFF : (b == 1) ? 32'h0100_0000 :
                 (b == 2) ? 32'hF000_0000 : 32'hFFFF_0000;
        end
      endcase
      fc = 3'($urandom);
      cycleStart = ($urandom_range(0, 2) == 0);
      cycleEnd = ($urandom_range(0, 2) == 0);
      cfgLoad = ($urandom_range(0, 7) == 0);
      cfgForceD16 = 1'($urandom); cfgForceA24 = 1'($urandom);
      cfgForceA16 = ($urandom_range(0, 3) == 0);
      cfgProgEn = ($urandom_range(0, 3) == 0);
      cfgProgAm = 6'($urandom);
    end
    @(negedge clk);
    cycleStart = 0; cycleEnd = 0; cfgLoad = 0;
    repeat (2) @(negedge clk);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule